// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block holds a 16-bit program counter and an 8-bit stack pointer into a private byte-wide stack memory. It carries out one control request per accepted cycle. The request kinds are: a plain advance past the current instruction, a relative branch, a long jump, a jump within the current 2K page, a long call, an in-page call, a return, a push and a pop. It also computes the fused decisions of a decrement-and-branch-if-nonzero request and a compare-and-branch-if-unequal request, and forms a code-memory address from the accumulator plus either the data pointer or the advanced program counter. Fetch and decode are done elsewhere. A decoder presents the request kind, the instruction length and the operand fields.

A small state machine sequences the block. Its states are `ST_IDLE`, `ST_CALL_HI` and `ST_RET_LO`.

- In `ST_IDLE` the block accepts any request. Most requests finish there, and the machine stays in `ST_IDLE`.
- A call moves `ST_IDLE -> ST_CALL_HI`. In that cycle it writes the low byte of the return address. The next cycle writes the high byte, loads the target and returns `ST_CALL_HI -> ST_IDLE`.
- A return moves `ST_IDLE -> ST_RET_LO`. In that cycle it pops the high byte. The next cycle pops the low byte, reloads the counter and returns `ST_RET_LO -> ST_IDLE`.

While the machine is outside `ST_IDLE`, `busy` is high and request inputs are ignored.

Top module: `pcstk_unit`

## Requirements
- R1: While reset is asserted and after it is released, the counter is 0000h, the stack pointer is 07h, and busy, taken and pop_valid are low.
- R2: req_op codes are 0 none, 1 advance, 2 relative, 3 long jump, 4 page jump, 5 long call, 6 page call, 7 return, 8 push, 9 pop, 10 decrement-branch, 11 compare-branch, 12 code address from counter, 13 code address from data pointer; 14 and 15 act as code 0. Advance adds req_len to the counter, and codes 0, 14 and 15 change no output.
- R3: A relative branch sets the counter to counter + req_len + sign-extended req_disp, modulo 2^16, covering displacements -128 to +127.
- R4: A long jump loads req_addr into the counter.
- R5: A page jump, and the target of a page call, keep bits 15:11 of counter + req_len and take bits 10:0 from req_addr, even when the advance crosses a 2K boundary.
- R6: A call pushes the low byte and then the high byte of counter + req_len, each with a pre-increment, so the stack pointer rises by 2. busy is high for the one cycle after acceptance, and the counter takes the target (req_addr for a long call, the R5 page target for a page call) when busy falls.
- R7: A return pops the high byte and then the low byte, each with a post-decrement. It restores the counter saved by the matching call after two cycles, and the stack pointer falls by 2.
- R8: A push increments the stack pointer, writes req_data at the new pointer, and advances the counter by req_len.
- R9: A pop drives the byte at the current pointer on pop_data with pop_valid high for exactly one cycle, decrements the pointer, and advances the counter by req_len.
- R10: A decrement-branch sets cnt_out to cnt_in - 1 modulo 256. taken is high for one cycle when that value is nonzero, and the counter follows R3 when taken and advances by req_len otherwise.
- R11: A compare-branch raises taken for one cycle when cmp_a differs from cmp_b, with the counter as in R10. cy is set when cmp_a is unsigned-less than cmp_b and cleared otherwise.
- R12: The code address is acc zero-extended plus either dptr or counter + req_len, modulo 2^16. The counter advances by req_len, and cy does not change.
- R13: Requests presented while busy is high change nothing: the call or return completes exactly as if req_valid were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Request kind (codes in R2) |
| req_len | input | 2 | Length of the current instruction in bytes |
| req_disp | input | 8 | Signed relative displacement |
| req_addr | input | 16 | Long target; bits 10:0 are the page offset |
| req_data | input | 8 | Byte to push |
| cnt_in | input | 8 | Count for decrement-branch |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| acc | input | 8 | Accumulator for code addressing |
| dptr | input | 16 | Data pointer for code addressing |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Second cycle of a call or return in progress |
| taken | output | 1 | Branch decision pulse |
| cnt_out | output | 8 | Decremented count |
| cy | output | 1 | Compare less-than flag |
| pop_valid | output | 1 | pop_data is valid |
| pop_data | output | 8 | Popped byte |
| code_addr | output | 16 | Formed code address |

## Verification
The collision of interest is a new request arriving in the second cycle of a call or return. In that cycle the stack port is already busy writing the high return byte or reading the low one. The bench provokes it by holding req_valid with a push or another call through that cycle. The behavioural model drops any request seen while its own phase is nonzero, and the pointer, counter and later pops must match it. A second overlap is the page target formed from an advanced counter that crosses a 2K boundary in the same cycle, which is judged by the upper five bits of the result.

// File: rtl/pcstk_pkg.sv
package pcstk_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_ADV     = 4'd1,
        OP_REL     = 4'd2,
        OP_LJMP    = 4'd3,
        OP_PJMP    = 4'd4,
        OP_LCALL   = 4'd5,
        OP_PCALL   = 4'd6,
        OP_RET     = 4'd7,
        OP_PUSH    = 4'd8,
        OP_POP     = 4'd9,
        OP_DECBR   = 4'd10,
        OP_CMPBR   = 4'd11,
        OP_CODE_PC = 4'd12,
        OP_CODE_DP = 4'd13
    } ctl_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CALL_HI = 2'd1,
        ST_RET_LO  = 2'd2
    } seq_st_e;

endpackage

// File: rtl/pcstk_target.sv
module pcstk_target #(
    parameter int DW     = 8,
    parameter int PAGE_W = 11
) (
    input  logic [2*DW-1:0] pc_cur,
    input  logic [1:0]      len,
    input  logic [DW-1:0]   disp,
    input  logic [2*DW-1:0] addr,
    input  logic [DW-1:0]   acc,
    input  logic [2*DW-1:0] dptr,
    output logic [2*DW-1:0] seq_pc,
    output logic [2*DW-1:0] rel_pc,
    output logic [2*DW-1:0] page_pc,
    output logic [2*DW-1:0] code_pc,
    output logic [2*DW-1:0] code_dp
);
    localparam int PC_W = 2 * DW;

    logic [PC_W-1:0] disp_sx;
    logic [PC_W-1:0] acc_zx;

    assign disp_sx = {{(PC_W-DW){disp[DW-1]}}, disp};
    assign acc_zx  = {{(PC_W-DW){1'b0}}, acc};

    assign seq_pc  = pc_cur + PC_W'(len);
    assign rel_pc  = seq_pc + disp_sx;
    assign page_pc = {seq_pc[PC_W-1:PAGE_W], addr[PAGE_W-1:0]};
    assign code_pc = seq_pc + acc_zx;
    assign code_dp = dptr + acc_zx;
endmodule

// File: rtl/pcstk_branch.sv
module pcstk_branch #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] cnt_in,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] dec_val,
    output logic          dec_nz,
    output logic          ne,
    output logic          lt
);
    assign dec_val = cnt_in - DW'(1);
    assign dec_nz  = |dec_val;
    assign ne      = (op_a != op_b);
    assign lt      = (op_a < op_b);
endmodule

// File: rtl/pcstk_ram.sv
module pcstk_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pcstk_unit.sv
module pcstk_unit
    import pcstk_pkg::*;
#(
    parameter int          DW     = 8,
    parameter int          SP_W   = 8,
    parameter int          PAGE_W = 11,
    parameter logic [7:0]  SP_RST = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_op,
    input  logic [1:0]       req_len,
    input  logic [DW-1:0]    req_disp,
    input  logic [2*DW-1:0]  req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic [DW-1:0]    cnt_in,
    input  logic [DW-1:0]    cmp_a,
    input  logic [DW-1:0]    cmp_b,
    input  logic [DW-1:0]    acc,
    input  logic [2*DW-1:0]  dptr,
    output logic [2*DW-1:0]  pc,
    output logic [SP_W-1:0]  sp,
    output logic             busy,
    output logic             taken,
    output logic [DW-1:0]    cnt_out,
    output logic             cy,
    output logic             pop_valid,
    output logic [DW-1:0]    pop_data,
    output logic [2*DW-1:0]  code_addr
);
    localparam int PC_W = 2 * DW;

    seq_st_e         state_q, state_d;
    ctl_op_e         op;
    logic            accept;

    logic [PC_W-1:0] pc_q, pc_d, tgt_q, tgt_d, caddr_q, caddr_d;
    logic [SP_W-1:0] sp_q, sp_d;
    logic [DW-1:0]   hi_q, hi_d, popd_q, popd_d, cnt_q, cnt_d;
    logic            taken_q, taken_d, popv_q, popv_d, cy_q, cy_d;

    logic            st_we;
    logic [SP_W-1:0] st_waddr, st_raddr;
    logic [DW-1:0]   st_wdata, st_rdata;

    logic [PC_W-1:0] seq_pc, rel_pc, page_pc, code_pc, code_dp;
    logic [DW-1:0]   dec_val;
    logic            dec_nz, cmp_ne, cmp_lt;

    assign op     = ctl_op_e'(req_op);
    assign accept = req_valid && (state_q == ST_IDLE);

    pcstk_target #(.DW(DW), .PAGE_W(PAGE_W)) tgt_i (
        .pc_cur (pc_q),
        .len    (req_len),
        .disp   (req_disp),
        .addr   (req_addr),
        .acc    (acc),
        .dptr   (dptr),
        .seq_pc (seq_pc),
        .rel_pc (rel_pc),
        .page_pc(page_pc),
        .code_pc(code_pc),
        .code_dp(code_dp)
    );

    pcstk_branch #(.DW(DW)) br_i (
        .cnt_in (cnt_in),
        .op_a   (cmp_a),
        .op_b   (cmp_b),
        .dec_val(dec_val),
        .dec_nz (dec_nz),
        .ne     (cmp_ne),
        .lt     (cmp_lt)
    );

    pcstk_ram #(.AW(SP_W), .DW(DW)) ram_i (
        .clk  (clk),
        .we   (st_we),
        .waddr(st_waddr),
        .wdata(st_wdata),
        .raddr(st_raddr),
        .rdata(st_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath decisions
    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        sp_d     = sp_q;
        tgt_d    = tgt_q;
        hi_d     = hi_q;
        popd_d   = popd_q;
        cnt_d    = cnt_q;
        cy_d     = cy_q;
        caddr_d  = caddr_q;
        taken_d  = 1'b0;
        popv_d   = 1'b0;
        st_we    = 1'b0;
        st_waddr = sp_q + SP_W'(1);
        st_wdata = '0;
        st_raddr = sp_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    case (op)
                        OP_ADV:  pc_d = seq_pc;
                        OP_REL:  pc_d = rel_pc;
                        OP_LJMP: pc_d = req_addr;
                        OP_PJMP: pc_d = page_pc;
                        OP_LCALL, OP_PCALL: begin
                            st_we    = 1'b1;
                            st_wdata = seq_pc[DW-1:0];
                            sp_d     = sp_q + SP_W'(1);
                            hi_d     = seq_pc[PC_W-1:DW];
                            tgt_d    = (op == OP_LCALL) ? req_addr : page_pc;
                            state_d  = ST_CALL_HI;
                        end
                        OP_RET: begin
                            hi_d    = st_rdata;
                            sp_d    = sp_q - SP_W'(1);
                            state_d = ST_RET_LO;
                        end
                        OP_PUSH: begin
                            st_we    = 1'b1;
                            st_wdata = req_data;
                            sp_d     = sp_q + SP_W'(1);
                            pc_d     = seq_pc;
                        end
                        OP_POP: begin
                            popd_d = st_rdata;
                            popv_d = 1'b1;
                            sp_d   = sp_q - SP_W'(1);
                            pc_d   = seq_pc;
                        end
                        OP_DECBR: begin
                            cnt_d   = dec_val;
                            taken_d = dec_nz;
                            pc_d    = dec_nz ? rel_pc : seq_pc;
                        end
                        OP_CMPBR: begin
                            cy_d    = cmp_lt;
                            taken_d = cmp_ne;
                            pc_d    = cmp_ne ? rel_pc : seq_pc;
                        end
                        OP_CODE_PC: begin
                            caddr_d = code_pc;
                            pc_d    = seq_pc;
                        end
                        OP_CODE_DP: begin
                            caddr_d = code_dp;
                            pc_d    = seq_pc;
                        end
                        default: ;
                    endcase
                end
            end
            ST_CALL_HI: begin
                st_we    = 1'b1;
                st_wdata = hi_q;
                sp_d     = sp_q + SP_W'(1);
                pc_d     = tgt_q;
                state_d  = ST_IDLE;
            end
            ST_RET_LO: begin
                pc_d    = {hi_q, st_rdata};
                sp_d    = sp_q - SP_W'(1);
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            sp_q    <= SP_RST[SP_W-1:0];
            tgt_q   <= '0;
            hi_q    <= '0;
            popd_q  <= '0;
            cnt_q   <= '0;
            cy_q    <= 1'b0;
            caddr_q <= '0;
            taken_q <= 1'b0;
            popv_q  <= 1'b0;
        end else begin
            pc_q    <= pc_d;
            sp_q    <= sp_d;
            tgt_q   <= tgt_d;
            hi_q    <= hi_d;
            popd_q  <= popd_d;
            cnt_q   <= cnt_d;
            cy_q    <= cy_d;
            caddr_q <= caddr_d;
            taken_q <= taken_d;
            popv_q  <= popv_d;
        end
    end

    assign pc        = pc_q;
    assign sp        = sp_q;
    assign busy      = (state_q != ST_IDLE);
    assign taken     = taken_q;
    assign cnt_out   = cnt_q;
    assign cy        = cy_q;
    assign pop_valid = popv_q;
    assign pop_data  = popd_q;
    assign code_addr = caddr_q;

    // R8
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_PUSH) |=> (sp == $past(sp) + SP_W'(1)));

    // R6
    call_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_LCALL || op == OP_PCALL)) |=> busy ##1 !busy);

    // R7
    ret_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_RET) |=> busy ##1 (!busy && sp == $past(sp, 2) - SP_W'(2)));

    // R9
    pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> $past(accept && op == OP_POP));

    // R10
    decbr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_DECBR) |=> (cnt_out == $past(cnt_in) - DW'(1)) && (taken == (cnt_out != '0)));

    // R11
    taken_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> $past(accept && (op == OP_DECBR || op == OP_CMPBR)));

    // R13
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
endmodule

// File: tb/pcstk_unit_tb_top.sv
module pcstk_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic [1:0]  req_len = '0;
    logic [7:0]  req_disp = '0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [7:0]  cnt_in = '0;
    logic [7:0]  cmp_a = '0;
    logic [7:0]  cmp_b = '0;
    logic [7:0]  acc = '0;
    logic [15:0] dptr = '0;
    logic [15:0] pc, code_addr;
    logic [7:0]  sp, cnt_out, pop_data;
    logic        busy, taken, cy, pop_valid;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    armed = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    pcstk_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_len(req_len), .req_disp(req_disp), .req_addr(req_addr),
        .req_data(req_data), .cnt_in(cnt_in), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .acc(acc), .dptr(dptr), .pc(pc), .sp(sp), .busy(busy), .taken(taken),
        .cnt_out(cnt_out), .cy(cy), .pop_valid(pop_valid), .pop_data(pop_data),
        .code_addr(code_addr)
    );

    // Behavioural reference model
    logic [15:0] m_pc = 16'h0000, m_tgt = '0, m_caddr = '0;
    logic [7:0]  m_sp = 8'h07, m_hi = '0, m_popd = '0, m_cnt = '0;
    logic [7:0]  m_mem [256];
    logic        m_taken = 0, m_popv = 0, m_cy = 0;
    int          m_phase = 0;

    always @(posedge clk) begin
        logic [15:0] nxt, br;
        armed <= 1'b1;
        nxt = m_pc + {14'd0, req_len};
        br  = nxt + {{8{req_disp[7]}}, req_disp};
        m_taken = 0;
        m_popv  = 0;
        if (!rst_n) begin
            m_pc = '0; m_sp = 8'h07; m_phase = 0; m_tgt = '0; m_hi = '0;
            m_popd = '0; m_cnt = '0; m_cy = 0; m_caddr = '0;
        end else if (m_phase == 1) begin
            m_sp = m_sp + 8'd1;
            m_mem[m_sp] = m_hi;
            m_pc = m_tgt;
            m_phase = 0;
        end else if (m_phase == 2) begin
            m_pc = {m_hi, m_mem[m_sp]};
            m_sp = m_sp - 8'd1;
            m_phase = 0;
        end else if (req_valid) begin
            case (req_op)
                4'd1: m_pc = nxt;
                4'd2: m_pc = br;
                4'd3: m_pc = req_addr;
                4'd4: m_pc = {nxt[15:11], req_addr[10:0]};
                4'd5, 4'd6: begin
                    m_sp = m_sp + 8'd1;
                    m_mem[m_sp] = nxt[7:0];
                    m_hi = nxt[15:8];
                    m_tgt = (req_op == 4'd5) ? req_addr : {nxt[15:11], req_addr[10:0]};
                    m_phase = 1;
                end
                4'd7: begin
                    m_hi = m_mem[m_sp];
                    m_sp = m_sp - 8'd1;
                    m_phase = 2;
                end
                4'd8: begin
                    m_sp = m_sp + 8'd1;
                    m_mem[m_sp] = req_data;
                    m_pc = nxt;
                end
                4'd9: begin
                    m_popd = m_mem[m_sp];
                    m_popv = 1;
                    m_sp = m_sp - 8'd1;
                    m_pc = nxt;
                end
                4'd10: begin
                    m_cnt = cnt_in - 8'd1;
                    m_taken = (m_cnt != 0);
                    m_pc = m_taken ? br : nxt;
                end
                4'd11: begin
                    m_taken = (cmp_a != cmp_b);
                    m_cy = (cmp_a < cmp_b);
                    m_pc = m_taken ? br : nxt;
                end
                4'd12: begin m_caddr = nxt + {8'd0, acc}; m_pc = nxt; end
                4'd13: begin m_caddr = dptr + {8'd0, acc}; m_pc = nxt; end
                default: ;
            endcase
        end
    end

    task automatic chk(string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            chk("pc", pc, m_pc);
            chk("sp", sp, m_sp);
            chk("busy", busy, m_phase != 0);
            chk("taken", taken, m_taken);
            chk("pop_valid", pop_valid, m_popv);
            if (m_popv) chk("pop_data", pop_data, m_popd);
            chk("cnt_out", cnt_out, m_cnt);
            chk("cy", cy, m_cy);
            chk("code_addr", code_addr, m_caddr);
        end
    end

    task automatic rq(string t, logic [3:0] op, logic [1:0] len,
                      logic [7:0] disp, logic [15:0] addr, logic [7:0] data);
        tag       = t;
        req_valid = 1'b1;
        req_op    = op;
        req_len   = len;
        req_disp  = disp;
        req_addr  = addr;
        req_data  = data;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        rst_n = 1'b1;
        idle(2);
        // R2 advance and inert codes
        rq("R2", 4'd1, 2'd1, 0, 0, 0);
        rq("R2", 4'd1, 2'd3, 0, 0, 0);
        rq("R2", 4'd0, 2'd2, 0, 16'h1234, 0);
        rq("R2", 4'd15, 2'd2, 0, 16'h1234, 0);
        // R3 relative reach
        rq("R3", 4'd2, 2'd2, 8'h05, 0, 0);
        rq("R3", 4'd2, 2'd2, 8'h80, 0, 0);
        rq("R3", 4'd2, 2'd2, 8'h7F, 0, 0);
        rq("R3", 4'd2, 2'd2, 8'h80, 0, 0);
        // R4, R5
        rq("R4", 4'd3, 2'd3, 0, 16'h7FF0, 0);
        rq("R5", 4'd4, 2'd2, 0, 16'hF123, 0);
        rq("R4", 4'd3, 2'd3, 0, 16'h07FF, 0);
        rq("R5", 4'd4, 2'd2, 0, 16'h0055, 0);
        // R8, R9
        rq("R8", 4'd8, 2'd2, 0, 0, 8'hA5);
        rq("R8", 4'd8, 2'd2, 0, 0, 8'h3C);
        rq("R9", 4'd9, 2'd2, 0, 0, 0);
        rq("R9", 4'd9, 2'd2, 0, 0, 0);
        // R6 long call, with a request held in the busy cycle (R13)
        rq("R6", 4'd5, 2'd3, 0, 16'h4000, 0);
        rq("R13", 4'd8, 2'd2, 0, 0, 8'hEE);
        idle(1);
        rq("R6", 4'd6, 2'd2, 0, 16'h07AB, 0);
        rq("R13", 4'd5, 2'd3, 0, 16'h9999, 0);
        idle(1);
        // R7 returns, second one with a held request
        rq("R7", 4'd7, 2'd1, 0, 0, 0);
        idle(2);
        rq("R7", 4'd7, 2'd1, 0, 0, 0);
        rq("R13", 4'd3, 2'd3, 0, 16'hBEEF, 0);
        idle(1);
        // R10
        cnt_in = 8'd1; rq("R10", 4'd10, 2'd2, 8'hFD, 0, 0);
        cnt_in = 8'd5; rq("R10", 4'd10, 2'd2, 8'hFD, 0, 0);
        cnt_in = 8'd0; rq("R10", 4'd10, 2'd2, 8'h10, 0, 0);
        // R11
        cmp_a = 8'd3; cmp_b = 8'd9; rq("R11", 4'd11, 2'd3, 8'h08, 0, 0);
        cmp_a = 8'd9; cmp_b = 8'd3; rq("R11", 4'd11, 2'd3, 8'hF0, 0, 0);
        cmp_a = 8'h44; cmp_b = 8'h44; rq("R11", 4'd11, 2'd3, 8'h20, 0, 0);
        // R12
        acc = 8'hFF; rq("R12", 4'd12, 2'd1, 0, 0, 0);
        acc = 8'h20; dptr = 16'hFFF0; rq("R12", 4'd13, 2'd1, 0, 0, 0);
        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule